// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of a free-running 16-bit timer at the moment a qualifying event is seen on an asynchronous input pin. The pin is brought into the clock domain by a two-flop synchronizer and then edge-detected. A small state machine, loaded through a 4-bit mode write port, decides which detected edges count as capture events. The choices are every falling edge, every rising edge, every fourth rising edge and every sixteenth rising edge.

On each capture the timer value is stored in a capture register and a sticky flag is raised. Software lowers the flag with a one-cycle clear strobe. The prescaler counter behind the divided modes is cleared only while the unit is off. Moving from one divided mode directly to another keeps the partial count. Software that wants a clean count writes the off code first and then the new mode.

The state machine has five states: OFF, FALL, RISE, DIV4 and DIV16. Any mode write moves it to the state that the written code selects. An unlisted code leads to OFF. With no write, the machine stays in its current state.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, the capture register is 0, the flag is 0, the unit is in the OFF state and the prescaler count is 0.
- R2: Mode codes are 4'b0000 OFF, 4'b0100 FALL, 4'b0101 RISE, 4'b0110 DIV4 and 4'b0111 DIV16. Every other code selects OFF. In OFF no capture occurs and the flag does not change on pin activity.
- R3: In FALL mode, every falling edge of the pin causes a capture. The value captured is the timer value present on the third rising clock edge after the pin changes, counting two synchronizer stages and one edge stage. The register and the flag show the capture after that clock edge.
- R4: In RISE mode, every rising edge of the pin captures with the same timing as R3, and falling edges are ignored.
- R5: In DIV4 mode, a capture occurs on every fourth rising edge, counted from a cleared prescaler.
- R6: In DIV16 mode, a capture occurs on every sixteenth rising edge, counted from a cleared prescaler.
- R7: The flag stays set until a clear strobe arrives. A clear strobe with no capture in the same cycle lowers the flag on the next clock edge.
- R8: When a clear strobe and a capture fall on the same clock edge, the flag ends up set.
- R9: A new capture overwrites the capture register even if the earlier value was never read. Without a capture, the register holds its value.
- R10: The prescaler counts rising edges in every capture mode and is cleared while the unit is OFF. A direct switch from DIV4 to DIV16 keeps the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Free-running timer value |
| cap_pin | input | 1 | Asynchronous capture input pin |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 4 | Mode code to write |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| cap_value | output | 16 | Capture register |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The assertions assume that every input is at a known level from reset onward. They also assume that the timer value is sampled at the same clock edge as the capture event, so the stored value can be compared with the previous cycle's timer input. The stimulus drives all inputs on the falling clock edge, including the pin. The synchronizer therefore sees clean levels, and each pin level lasts at least one full cycle. Mode writes use listed codes, unlisted codes and direct switches between the divided modes, so the clear-on-OFF and keep-count paths are both reached.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_FALL,
        ST_RISE,
        ST_DIV4,
        ST_DIV16
    } cap_state_t;

    localparam logic [MODE_W-1:0] CODE_OFF   = 4'b0000;
    localparam logic [MODE_W-1:0] CODE_FALL  = 4'b0100;
    localparam logic [MODE_W-1:0] CODE_RISE  = 4'b0101;
    localparam logic [MODE_W-1:0] CODE_DIV4  = 4'b0110;
    localparam logic [MODE_W-1:0] CODE_DIV16 = 4'b0111;

    // Unlisted codes fall back to the OFF state.
    function automatic cap_state_t decode_mode(input logic [MODE_W-1:0] code);
        cap_state_t s;
        case (code)
            CODE_FALL:  s = ST_FALL;
            CODE_RISE:  s = ST_RISE;
            CODE_DIV4:  s = ST_DIV4;
            CODE_DIV16: s = ST_DIV16;
            default:    s = ST_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev_lvl;
    logic              lvl;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign lvl = chain[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= lvl;
    end

    assign rise = lvl & ~prev_lvl;
    assign fall = ~lvl & prev_lvl;
endmodule

// File: rtl/ecap_mode_fsm.sv
module ecap_mode_fsm
    import ecap_pkg::*;
#(
    parameter int PS_W        = 4,
    parameter int DIV_LO_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic [PS_W-1:0]   ps_cnt,
    output cap_state_t        state,
    output logic              fire
);
    cap_state_t state_q;
    cap_state_t state_d;

    // Next-state logic: any write selects the state for the written code.
    always_comb begin
        state_d = state_q;
        if (mode_we) state_d = decode_mode(mode_wdata);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Output process: decide whether this cycle's edge is a capture event.
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_OFF:   fire = 1'b0;
            ST_FALL:  fire = fall;
            ST_RISE:  fire = rise;
            ST_DIV4:  fire = rise && (&ps_cnt[DIV_LO_BITS-1:0]);
            ST_DIV16: fire = rise && (&ps_cnt);
            default:  fire = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/ecap_prescaler.sv
module ecap_prescaler
    import ecap_pkg::*;
#(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cap_state_t      state,
    input  logic            rise,
    output logic [PS_W-1:0] cnt
);
    localparam logic [PS_W-1:0] ONE = {{(PS_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (state == ST_OFF) cnt <= '0;
        else if (rise)            cnt <= cnt + ONE;
    end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecap_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PS_W        = 4,
    parameter int DIV_LO_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  timer_val,
    input  logic              cap_pin,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              flag_clr,
    output logic [TMR_W-1:0]  cap_value,
    output logic              cap_flag
);
    logic            rise;
    logic            fall;
    logic            fire;
    logic [PS_W-1:0] ps_cnt;
    cap_state_t      state;
    logic            in_off;

    ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cap_pin),
        .rise      (rise),
        .fall      (fall)
    );

    ecap_mode_fsm #(.PS_W(PS_W), .DIV_LO_BITS(DIV_LO_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .rise       (rise),
        .fall       (fall),
        .ps_cnt     (ps_cnt),
        .state      (state),
        .fire       (fire)
    );

    ecap_prescaler #(.PS_W(PS_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .rise  (rise),
        .cnt   (ps_cnt)
    );

    assign in_off = (state == ST_OFF);

    // Capture register: a new event overwrites the old value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap_value <= '0;
        else if (fire) cap_value <= timer_val;
    end

    // Sticky flag: a capture wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cap_flag <= 1'b0;
        else if (fire)     cap_flag <= 1'b1;
        else if (flag_clr) cap_flag <= 1'b0;
    end
endmodule

// File: rtl/ecap_checker.sv
module ecap_checker #(
    parameter int TMR_W = 16,
    parameter int PS_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TMR_W-1:0] timer_val,
    input logic             flag_clr,
    input logic             fire,
    input logic             in_off,
    input logic [PS_W-1:0]  ps_cnt,
    input logic [TMR_W-1:0] cap_value,
    input logic             cap_flag
);
    assert_off_no_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_off |-> !fire);

    assert_capture_timer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cap_value == $past(timer_val));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !fire) |=> !cap_flag);

    assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cap_flag);

    assert_value_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cap_value));

    assert_off_clears_ps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_off |=> ps_cnt == '0);
endmodule

bind edge_capture_unit ecap_checker #(.TMR_W(TMR_W), .PS_W(PS_W)) u_ecap_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_val (timer_val),
    .flag_clr  (flag_clr),
    .fire      (fire),
    .in_off    (in_off),
    .ps_cnt    (ps_cnt),
    .cap_value (cap_value),
    .cap_flag  (cap_flag)
);

// File: tb/tb_edge_capture_unit.sv
`timescale 1ns/1ps
module tb_edge_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = 16'h1234;
    logic        cap_pin = 1'b0;
    logic        mode_we = 1'b0;
    logic [3:0]  mode_wdata = 4'h0;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_value;
    logic        cap_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    edge_capture_unit dut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cap_pin(cap_pin),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .flag_clr(flag_clr),
        .cap_value(cap_value), .cap_flag(cap_flag)
    );

    always @(negedge clk) timer_val <= timer_val + 16'd1;

    // Reference model derived from the requirements.
    logic [1:0]  m_sh;
    logic        m_prev;
    logic [3:0]  m_mode;
    logic [3:0]  m_cnt;
    logic [15:0] m_cap;
    logic        m_flag;

    function automatic bit valid_code(input logic [3:0] c);
        return (c == 4'b0100) || (c == 4'b0101) || (c == 4'b0110) || (c == 4'b0111);
    endfunction

    function automatic bit model_fire(input logic [3:0] mode, input logic [3:0] cnt,
                                      input bit rs, input bit fl);
        case (mode)
            4'b0100: return fl;
            4'b0101: return rs;
            4'b0110: return rs && (cnt[1:0] == 2'd3);
            4'b0111: return rs && (cnt == 4'd15);
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sh = 2'b00; m_prev = 1'b0; m_mode = 4'h0;
            m_cnt = 4'h0; m_cap = 16'h0; m_flag = 1'b0;
        end else begin
            bit lvl, rs, fl, f;
            lvl = m_sh[1];
            rs  = lvl && !m_prev;
            fl  = !lvl && m_prev;
            f   = model_fire(m_mode, m_cnt, rs, fl);
            if (f) m_cap = timer_val;
            if (f) m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            if (!valid_code(m_mode)) m_cnt = 4'h0;
            else if (rs) m_cnt = m_cnt + 4'd1;
            if (mode_we) m_mode = valid_code(mode_wdata) ? mode_wdata : 4'h0;
            m_prev = lvl;
            m_sh   = {m_sh[0], cap_pin};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (cap_value !== m_cap) begin
                errors++;
                $display("FAIL R3/R9 model capture: actual %h expected %h", cap_value, m_cap);
            end
            checks++;
            if (cap_flag !== m_flag) begin
                errors++;
                $display("FAIL R7/R8 model flag: actual %0d expected %0d", cap_flag, m_flag);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [3:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wdata = v;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic drive_pin(input logic level, output logic [15:0] exp_val);
        @(negedge clk); cap_pin = level;
        #1 exp_val = timer_val + 16'd2;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic rises(input int n);
        logic [15:0] e;
        for (int i = 0; i < n; i++) begin
            drive_pin(1'b1, e);
            drive_pin(1'b0, e);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] e1;
        logic [15:0] e2;
        logic [15:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", cap_value, 0);
        check("R1 reset flag", cap_flag, 0);

        // R2: OFF and unlisted codes ignore pin activity
        drive_pin(1'b1, e1); drive_pin(1'b0, e1);
        check("R2 off flag", cap_flag, 0);
        write_mode(4'b1010);
        drive_pin(1'b1, e1); drive_pin(1'b0, e1);
        check("R2 unlisted flag", cap_flag, 0);
        check("R2 unlisted value", cap_value, 0);

        // R4: rising mode
        write_mode(4'b0101);
        drive_pin(1'b1, e1);
        check("R4 rise value", cap_value, e1);
        check("R4 rise flag", cap_flag, 1);
        held = cap_value;
        drive_pin(1'b0, e2);
        check("R4 falling ignored", cap_value, held);

        // R7: sticky, then clear
        repeat (5) @(negedge clk);
        check("R7 flag sticky", cap_flag, 1);
        pulse_clear();
        check("R7 flag cleared", cap_flag, 0);

        // R9: overwrite without read
        drive_pin(1'b1, e1); drive_pin(1'b0, e2);
        drive_pin(1'b1, e2);
        check("R9 overwrite", cap_value, e2);

        // R8: clear collides with capture
        drive_pin(1'b0, e1);
        @(negedge clk); cap_pin = 1'b1;
        #1 e1 = timer_val + 16'd2;
        @(negedge clk);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R8 capture wins flag", cap_flag, 1);
        check("R8 capture wins value", cap_value, e1);

        // R3: falling mode
        write_mode(4'b0100);
        pulse_clear();
        drive_pin(1'b0, e1);
        check("R3 fall value", cap_value, e1);
        check("R3 fall flag", cap_flag, 1);

        // R5: divide by four from a cleared prescaler
        write_mode(4'b0000);
        write_mode(4'b0110);
        pulse_clear();
        rises(3);
        check("R5 no capture after 3", cap_flag, 0);
        drive_pin(1'b1, e1);
        check("R5 capture on 4th", cap_value, e1);
        check("R5 flag on 4th", cap_flag, 1);
        drive_pin(1'b0, e2);

        // R10: direct switch keeps count (2 rises in DIV4, 14 more in DIV16)
        write_mode(4'b0000);
        write_mode(4'b0110);
        pulse_clear();
        rises(2);
        write_mode(4'b0111);
        rises(13);
        check("R10 kept count not yet", cap_flag, 0);
        drive_pin(1'b1, e1);
        check("R10 kept count capture", cap_value, e1);
        drive_pin(1'b0, e2);

        // R6: divide by sixteen after OFF clears the count
        write_mode(4'b0000);
        write_mode(4'b0111);
        pulse_clear();
        rises(15);
        check("R6 no capture after 15", cap_flag, 0);
        drive_pin(1'b1, e1);
        check("R6 capture on 16th", cap_value, e1);
        drive_pin(1'b0, e2);

        // Random phase, checked by the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom % 3 == 0) cap_pin = ~cap_pin;
            flag_clr = ($urandom % 8 == 0);
            mode_we = ($urandom % 50 == 0);
            case ($urandom % 6)
                0: mode_wdata = 4'b0000;
                1: mode_wdata = 4'b0100;
                2: mode_wdata = 4'b0101;
                3: mode_wdata = 4'b0110;
                4: mode_wdata = 4'b0111;
                default: mode_wdata = 4'($urandom);
            endcase
        end
        @(negedge clk);
        mode_we = 1'b0; flag_clr = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule